// File: doc/BRIEF.md
# Coprocessor Instruction Dispatch Arbiter

This block sits beside the decode stage of a host processor. When the decoder meets an instruction word it cannot identify, it hands that word to the arbiter. The arbiter broadcasts the word to every attached coprocessor for one cycle. One cycle later it samples their claim lines. If no unit claims the word, it raises a one-cycle illegal-opcode exception to the host. The exception carries the offending word.

If one or more units claim the word, the lowest-numbered claimant wins. The word goes to that unit over a per-port valid/ready handoff. The arbiter keeps one busy bit per coprocessor. A handoff sets the bit, and a done pulse from the unit clears it. If a newly claimed word targets a unit that is still busy, the arbiter holds the host stall line high until that unit reports done. Only then does it offer the word.

Top module: `cop_dispatch`

## Requirements
- R1: After a synchronous active-low reset, every busy bit is 0 and `poll_strobe`, `exc_pulse`, `host_stall` and `cp_valid` are all low.
- R2: `unk_valid` is sampled high while the arbiter is idle. In the next cycle `poll_strobe` is high for exactly one cycle and `poll_word` equals the sampled `unk_word`.
- R3: `claim` is sampled only in the cycle right after the `poll_strobe` cycle. Claims raised in any other cycle have no effect.
- R4: If the sampled claim vector is all zero, `exc_pulse` is high for exactly one cycle, in the cycle after the claim sample. `exc_word` carries the unclaimed word in that cycle.
- R5: If port k wins and is not busy, `cp_valid` is one-hot with bit k set, starting in the cycle after the claim sample. `cp_word` carries the word. Both hold unchanged until `cp_ready[k]` is high.
- R6: When several claim bits are set, the port with the lowest index wins. Claim bit i belongs to port i.
- R7: A handoff (`cp_valid[k]` and `cp_ready[k]` both high) sets `cp_busy[k]` from the next cycle. A `cp_done[k]` pulse with no handoff on port k clears it from the next cycle.
- R8: If the winning port is busy, `host_stall` is high from the cycle after the claim sample until one cycle after that port's busy bit clears. `cp_valid` rises in the cycle after that, and `cp_valid` never asserts toward a busy port.
- R9: `unk_valid` is ignored while a dispatch is in progress. It causes no further poll strobe.
- R10: If a handoff and a done pulse occur on the same port in the same cycle, the port's busy bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| unk_valid | input | 1 | Host decoder flags an unidentified instruction |
| unk_word | input | 32 | The unidentified instruction word |
| host_stall | output | 1 | Host must hold: the winning coprocessor is busy |
| exc_pulse | output | 1 | One-cycle illegal-opcode exception |
| exc_word | output | 32 | Word that no unit claimed (valid with `exc_pulse`) |
| poll_strobe | output | 1 | Broadcast strobe to all coprocessors |
| poll_word | output | 32 | Broadcast instruction word |
| claim | input | 4 | Per-port claim answers, sampled one cycle after the strobe |
| cp_valid | output | 4 | Per-port handoff valid, one-hot |
| cp_word | output | 32 | Instruction word offered to the winner |
| cp_ready | input | 4 | Per-port handoff ready |
| cp_done | input | 4 | Per-port completion pulse |
| cp_busy | output | 4 | Per-port busy status |

## Verification
A wrong busy bit shows up on `cp_busy` in the cycle after the handoff or done pulse that should have changed it. The same fault then shows as a missing or unwanted `host_stall` on the next dispatch aimed at that port. A sequencer that leaves its states in the wrong order, or at the wrong time, moves `poll_strobe`, `exc_pulse` or `cp_valid` by at least one cycle. Any such shift is visible at once against a cycle-accurate model. A wrong winner index appears on `cp_valid` in the first cycle of the offer.

// File: rtl/cpd_pkg.sv
// Shared types for the coprocessor dispatch arbiter.
// Assumes: nothing beyond a SystemVerilog-2017 compiler.
package cpd_pkg;

    // Sequencer phases of one dispatch
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_POLL   = 3'd1,
        PH_DECIDE = 3'd2,
        PH_EXC    = 3'd3,
        PH_WAIT   = 3'd4,
        PH_SEND   = 3'd5
    } phase_t;

endpackage

// File: rtl/cpd_claim_pick.sv
// Fixed-priority pick over the claim vector: the lowest set index wins.
// Assumes: NPORT >= 2; purely combinational.
module cpd_claim_pick #(
    parameter int NPORT = 4,
    localparam int IDXW = $clog2(NPORT)
) (
    input  logic [NPORT-1:0] claims,
    output logic             any_claim,
    output logic [IDXW-1:0]  win_idx
);

    // Scan from the top down so the lowest set index is written last
    always_comb begin
        win_idx = '0;
        for (int i = NPORT - 1; i >= 0; i--) begin
            if (claims[i]) win_idx = IDXW'(i);
        end
    end

    // Any port answering at all
    assign any_claim = |claims;

endmodule

// File: rtl/cpd_busy_track.sv
// One busy bit per coprocessor: set on handoff, cleared on done; set wins.
// Assumes: done pulses arrive only for ports that own work (not enforced).
module cpd_busy_track #(
    parameter int NPORT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPORT-1:0] set_hand,
    input  logic [NPORT-1:0] clr_done,
    output logic [NPORT-1:0] busy
);

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        // Per-port busy flag update
        always_ff @(posedge clk) begin
            if (!rst_n)            busy[g] <= 1'b0;
            else if (set_hand[g])  busy[g] <= 1'b1;
            else if (clr_done[g])  busy[g] <= 1'b0;
        end

        AST_BUSY_SET: assert property (@(posedge clk) disable iff (!rst_n)
            set_hand[g] |=> busy[g]); // R10
        AST_BUSY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_done[g] && !set_hand[g]) |=> !busy[g]); // R7
    end

endmodule

// File: rtl/cpd_seq.sv
// Dispatch sequencer: poll, sample claims, then raise an exception or
// wait for the winner to go idle and offer it the word.
// Assumes: claims are valid in the cycle after the poll strobe.
module cpd_seq
    import cpd_pkg::*;
#(
    parameter int NPORT = 4,
    parameter int WW    = 32,
    localparam int IDXW = $clog2(NPORT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             unk_valid,
    input  logic [WW-1:0]    unk_word,
    input  logic             any_claim,
    input  logic [IDXW-1:0]  win_idx,
    input  logic [NPORT-1:0] busy,
    input  logic [NPORT-1:0] cp_ready,
    output logic             poll_strobe,
    output logic             exc_pulse,
    output logic             host_stall,
    output logic [NPORT-1:0] cp_valid,
    output logic [NPORT-1:0] handoff,
    output logic [WW-1:0]    held_word
);

    phase_t          phase, phase_nx;
    logic [IDXW-1:0] win_q;
    logic            take_word;

    assign take_word = (phase == PH_IDLE) && unk_valid;

    // Next-phase selection
    always_comb begin
        phase_nx = phase;
        case (phase)
            PH_IDLE:   if (unk_valid) phase_nx = PH_POLL;
            PH_POLL:   phase_nx = PH_DECIDE;
            PH_DECIDE: begin
                if (!any_claim)         phase_nx = PH_EXC;
                else if (busy[win_idx]) phase_nx = PH_WAIT;
                else                    phase_nx = PH_SEND;
            end
            PH_EXC:    phase_nx = PH_IDLE;
            PH_WAIT:   if (!busy[win_q]) phase_nx = PH_SEND;
            PH_SEND:   if (cp_ready[win_q]) phase_nx = PH_IDLE;
            default:   phase_nx = PH_IDLE;
        endcase
    end

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_IDLE;
        else        phase <= phase_nx;
    end

    // Capture the word on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n)         held_word <= '0;
        else if (take_word) held_word <= unk_word;
    end

    // Record the winner at the claim sample
    always_ff @(posedge clk) begin
        if (!rst_n)                                 win_q <= '0;
        else if (phase == PH_DECIDE && any_claim)   win_q <= win_idx;
    end

    // Phase-decoded outputs
    always_comb begin
        cp_valid = '0;
        if (phase == PH_SEND) cp_valid[win_q] = 1'b1;
    end

    assign handoff     = cp_valid & cp_ready;
    assign poll_strobe = (phase == PH_POLL);
    assign exc_pulse   = (phase == PH_EXC);
    assign host_stall  = (phase == PH_WAIT);

    AST_VALID_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cp_valid)); // R5
    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (|cp_valid && !(|handoff)) |=> $stable(cp_valid) && $stable(held_word)); // R5
    AST_NO_SEND_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_valid & busy) == '0); // R8
    AST_STALL_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        host_stall |=> (host_stall || |cp_valid)); // R8
    AST_EXC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        exc_pulse |=> !exc_pulse); // R4
    AST_POLL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        poll_strobe |=> !poll_strobe); // R2
    AST_POLL_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        take_word |=> poll_strobe && (held_word == $past(unk_word))); // R2

endmodule

// File: rtl/cop_dispatch.sv
// Coprocessor dispatch arbiter top: broadcast poll, priority claim pick,
// exception or handoff, busy tracking and host stall.
// Assumes: the host presents unk_valid only while no dispatch is running.
module cop_dispatch #(
    parameter int NPORT = 4,
    parameter int WW    = 32,
    localparam int IDXW = $clog2(NPORT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             unk_valid,
    input  logic [WW-1:0]    unk_word,
    output logic             host_stall,
    output logic             exc_pulse,
    output logic [WW-1:0]    exc_word,
    output logic             poll_strobe,
    output logic [WW-1:0]    poll_word,
    input  logic [NPORT-1:0] claim,
    output logic [NPORT-1:0] cp_valid,
    output logic [WW-1:0]    cp_word,
    input  logic [NPORT-1:0] cp_ready,
    input  logic [NPORT-1:0] cp_done,
    output logic [NPORT-1:0] cp_busy
);

    logic            any_claim;
    logic [IDXW-1:0] win_idx;
    logic [NPORT-1:0] handoff;
    logic [WW-1:0]   held_word;

    cpd_claim_pick #(.NPORT(NPORT)) u_pick (
        .claims    (claim),
        .any_claim (any_claim),
        .win_idx   (win_idx)
    );

    cpd_busy_track #(.NPORT(NPORT)) u_busy (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_hand (handoff),
        .clr_done (cp_done),
        .busy     (cp_busy)
    );

    cpd_seq #(.NPORT(NPORT), .WW(WW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .unk_valid   (unk_valid),
        .unk_word    (unk_word),
        .any_claim   (any_claim),
        .win_idx     (win_idx),
        .busy        (cp_busy),
        .cp_ready    (cp_ready),
        .poll_strobe (poll_strobe),
        .exc_pulse   (exc_pulse),
        .host_stall  (host_stall),
        .cp_valid    (cp_valid),
        .handoff     (handoff),
        .held_word   (held_word)
    );

    // One word register feeds all three word outputs
    assign poll_word = held_word;
    assign exc_word  = held_word;
    assign cp_word   = held_word;

    AST_EXC_NEEDS_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        exc_pulse |-> $past(claim) == '0); // R4
    AST_STALL_IDLE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        host_stall |-> !poll_strobe && !exc_pulse && (cp_valid == '0)); // R8

endmodule

// File: tb/sim_cop_dispatch.sv
module sim_cop_dispatch;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        unk_valid = 1'b0;
    logic [31:0] unk_word = '0;
    logic [3:0]  claim = '0;
    logic [3:0]  cp_ready = 4'hF;
    logic [3:0]  cp_done = '0;
    logic        host_stall, exc_pulse, poll_strobe;
    logic [31:0] exc_word, poll_word, cp_word;
    logic [3:0]  cp_valid, cp_busy;

    int errors = 0;
    int checks = 0;
    int strobe_cnt = 0;
    int exc_cnt = 0;
    int last_sent = -1;

    always #2 clk = ~clk;   // 250 MHz

    cop_dispatch u0 (
        .clk(clk), .rst_n(rst_n), .unk_valid(unk_valid), .unk_word(unk_word),
        .host_stall(host_stall), .exc_pulse(exc_pulse), .exc_word(exc_word),
        .poll_strobe(poll_strobe), .poll_word(poll_word), .claim(claim),
        .cp_valid(cp_valid), .cp_word(cp_word), .cp_ready(cp_ready),
        .cp_done(cp_done), .cp_busy(cp_busy)
    );

    // Behavioural reference model
    int         m_ph = 0;   // 0 idle 1 poll 2 decide 3 exc 4 wait 5 send
    logic [31:0] m_word = '0;
    int         m_win = 0;
    bit [3:0]   m_busy = '0;

    always @(posedge clk) begin
        bit [3:0] hand;
        hand = '0;
        if (!rst_n) begin
            m_ph = 0; m_busy = '0; m_win = 0; m_word = '0;
        end else begin
            case (m_ph)
                0: if (unk_valid) begin m_word = unk_word; m_ph = 1; end
                1: m_ph = 2;
                2: begin
                    if (claim == 0) m_ph = 3;
                    else begin
                        m_win = 0;
                        while (!claim[m_win]) m_win++;
                        m_ph = m_busy[m_win] ? 4 : 5;
                    end
                end
                3: m_ph = 0;
                4: if (!m_busy[m_win]) m_ph = 5;
                5: if (cp_ready[m_win]) begin hand[m_win] = 1'b1; m_ph = 0; end
                default: m_ph = 0;
            endcase
            for (int i = 0; i < 4; i++) begin
                if (hand[i]) m_busy[i] = 1'b1;
                else if (cp_done[i]) m_busy[i] = 1'b0;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare against the model on every clock, away from the edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 poll_strobe", 32'(poll_strobe), 32'(m_ph == 1));
            if (m_ph == 1) chk("R2 poll_word", poll_word, m_word);
            chk("R4 exc_pulse", 32'(exc_pulse), 32'(m_ph == 3));
            if (m_ph == 3) chk("R4 exc_word", exc_word, m_word);
            chk("R8 host_stall", 32'(host_stall), 32'(m_ph == 4));
            chk("R5 cp_valid", 32'(cp_valid), (m_ph == 5) ? (32'd1 << m_win) : 32'd0);
            if (m_ph == 5) chk("R5 cp_word", cp_word, m_word);
            chk("R7 cp_busy", 32'(cp_busy), 32'(m_busy));
            if (poll_strobe) strobe_cnt++;
            if (exc_pulse) exc_cnt++;
            for (int i = 0; i < 4; i++) if (cp_valid[i] && cp_ready[i]) last_sent = i;
        end
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    // One dispatch: early=claim during the poll cycle, extra=unk during poll
    task automatic issue(input logic [31:0] w, input logic [3:0] mask,
                         input bit early, input bit extra);
        step(); unk_valid = 1'b1; unk_word = w;
        step(); unk_valid = extra; unk_word = ~w;
                claim = early ? mask : 4'h0;
        step(); unk_valid = 1'b0; claim = early ? 4'h0 : mask;
        step(); claim = 4'h0;
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int s0, e0;
        repeat (3) step();
        chk("R1 busy", 32'(cp_busy), 0);
        chk("R1 strobes", {28'b0, poll_strobe, exc_pulse, host_stall, |cp_valid}, 0);
        rst_n = 1'b1;
        step();
        chk("R1 idle after release", {28'b0, poll_strobe, exc_pulse, host_stall, |cp_valid}, 0);

        // R4: nobody claims
        e0 = exc_cnt;
        issue(32'hA1A1_0001, 4'h0, 0, 0);
        repeat (3) step();
        chk("R4 one exception", 32'(exc_cnt - e0), 1);

        // R5: single claim on port 2
        issue(32'hB2B2_0002, 4'b0100, 0, 0);
        repeat (3) step();
        chk("R5 sent port", 32'(last_sent), 2);

        // R6: two claimants, lowest wins
        issue(32'hC3C3_0003, 4'b1010, 0, 0);
        repeat (3) step();
        chk("R6 lowest wins", 32'(last_sent), 1);
        cp_done = 4'b0010; step(); cp_done = 4'h0; step();

        // R3: claim in the wrong cycle is ignored
        e0 = exc_cnt;
        issue(32'hD4D4_0004, 4'b0001, 1, 0);
        repeat (3) step();
        chk("R3 early claim ignored", 32'(exc_cnt - e0), 1);

        // R8: port 2 still busy -> stall until done
        issue(32'hE5E5_0005, 4'b0100, 0, 0);
        repeat (4) step();
        chk("R8 stalling", 32'(host_stall), 1);
        cp_done = 4'b0100; step(); cp_done = 4'h0;
        repeat (4) step();
        chk("R8 released", 32'(host_stall), 0);
        chk("R8 sent after stall", 32'(last_sent), 2);

        // R9: unk during dispatch is ignored
        s0 = strobe_cnt;
        issue(32'hF6F6_0006, 4'b0001, 0, 1);
        repeat (4) step();
        chk("R9 single strobe", 32'(strobe_cnt - s0), 1);

        // R10: handoff and done together on port 3, with ready held off first
        cp_ready = 4'b0111;
        issue(32'h0707_0007, 4'b1000, 0, 0);
        repeat (3) step();
        chk("R5 held while not ready", 32'(cp_valid), 32'b1000);
        cp_ready = 4'hF; cp_done = 4'b1000;
        step(); cp_done = 4'h0;
        step();
        chk("R10 set wins", 32'(cp_busy[3]), 1);
        cp_done = 4'b1111; step(); cp_done = 4'h0; step();
        chk("R7 all cleared", 32'(cp_busy), 0);

        repeat (3) step();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule